// File: doc/BRIEF.md
# Coalescing Store Write Buffer

This block sits between a processor store port and a memory write bus. Ordinary stores are captured into a small FIFO of entries. Each entry carries a start word address and up to four consecutive data words. A store to the word just after the youngest entry's last word extends that entry. A store to a word that is already pending replaces that word where it is held. Any other store opens a new entry. The buffered entries are later committed oldest first, one burst per entry.

The buffer empties itself in several cases: when it runs out of entries, when an entry reaches its word limit, or when the core raises an exception, barrier or sleep strobe. While it empties, the store port is held off. Stores tagged as uncacheable or device-like skip the buffer and go out as single-beat transfers. When buffering is switched off through the enable control, every store is sent this way. A skipping store that meets pending entries waits until they have drained, so the bus sees stores in program order.

Top module: `wrCoalesceBuffer`

## Requirements
- R1: After reset the buffer is empty (`bufEmpty`=1), `busValid`=0 and `stReady`=1.
- R2: A normal store whose word address equals the youngest entry's start plus its word count, while that entry holds fewer than 4 words, joins that entry. The entry later drains as one burst: `busAddr` is the start address, `busLen` is the word count, and the data follows in address order. Until a drain is triggered, nothing appears on the bus.
- R3: A normal store to a word address already held in a pending entry overwrites that word in place. The entry's length and the entry count are unchanged.
- R4: Any other normal store opens a new entry. Entries drain oldest first.
- R5: When a fourth entry is opened, or an entry reaches 4 words, draining starts in the next cycle. `stReady` stays 0 until the buffer is empty.
- R6: A one-cycle `evtExc`, `evtBarrier` or `evtSleep` strobe with entries pending starts a drain. The same strobe with an empty buffer has no effect: no bus activity and no stall.
- R7: A store with `stBypass`=1 that arrives at an empty buffer is accepted and issued in the next cycle as a single beat with `busLen`=1 and `busLast`=1. `stReady` is 0 until that beat is taken.
- R8: A bypass store that arrives while entries are pending is not accepted and forces a drain. It is issued only after the last buffered beat.
- R9: The enable control resets to 1. A cycle with `cfgWe`=1 loads `cfgEn`. While it is 0, every store is issued as its own single beat.
- R10: Every beat is a valid/ready handshake. `busAddr`, `busLen` and `busData` hold steady while `busValid`=1 and `busReady`=0. `busLast` marks the final beat of each burst.
- R11: `drainDone` pulses for exactly one cycle, in the cycle after the final buffered beat is taken, and `bufEmpty` is 1 in that cycle.
- R12: A normal store and a drain strobe in the same cycle: the store is accepted and is included in the drain it triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Load strobe for the buffering enable |
| cfgEn | input | 1 | New enable value (1 = buffer normal stores) |
| stValid | input | 1 | Store request valid |
| stReady | output | 1 | Store accepted in this cycle when high with stValid |
| stAddr | input | ADDR_W | Store word address |
| stData | input | DATA_W | Store data word |
| stBypass | input | 1 | Store must not be buffered (device, ordered, exclusive) |
| evtExc | input | 1 | Exception, interrupt, context switch or return strobe |
| evtBarrier | input | 1 | Synchronization barrier strobe |
| evtSleep | input | 1 | Sleep or deep-sleep entry strobe |
| busValid | output | 1 | Write beat valid |
| busReady | input | 1 | Write beat accepted |
| busAddr | output | ADDR_W | Burst start word address |
| busLen | output | 3 | Burst length in words (1 to 4) |
| busData | output | DATA_W | Beat data |
| busLast | output | 1 | Final beat of the burst |
| drainDone | output | 1 | One-cycle pulse when a drain has emptied the buffer |
| bufEmpty | output | 1 | No entries pending |

## Verification
The pairing that matters is a store being merged and a drain being triggered in the same cycle. The bench drives a store that extends the youngest entry together with a barrier strobe. It then checks that the resulting burst carries the merged word, with the longer length. A second collision comes from a bypass store that meets pending entries: the buffer drains and the single beat follows. The scoreboard's queue order judges whether the buffered burst reached the bus ahead of the single beat. Bus backpressure runs throughout, so merges and drains are also judged while beats are stalled.

// File: rtl/wcbPkg.sv
package wcbPkg;
  localparam int ENTRIES = 4;
  localparam int WORDS   = 4;
  localparam int ENT_W   = $clog2(ENTRIES);
  localparam int WORD_W  = $clog2(WORDS);
  localparam int LEN_W   = $clog2(WORDS + 1);
  localparam int CNT_W   = $clog2(ENTRIES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DRAIN, ST_BYPASS} wcbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              alloc;
    logic              append;
    logic              overwrite;
    logic              pop;
    logic              byLoad;
    logic              selBy;
    logic [ENT_W-1:0]  ent;
    logic [WORD_W-1:0] word;
  } wcbStb_t;
endpackage

// File: rtl/wcbData.sv
module wcbData
  import wcbPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  wcbStb_t           stb,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [ENT_W-1:0]  headIdx,
  input  logic [ENT_W-1:0]  youngIdx,
  input  logic [WORD_W-1:0] beatIdx,
  output logic              hit,
  output logic [ENT_W-1:0]  hitEnt,
  output logic [WORD_W-1:0] hitWord,
  output logic              appendOk,
  output logic [LEN_W-1:0]  youngLen,
  output logic [LEN_W-1:0]  headLen,
  output logic [ADDR_W-1:0] busAddr,
  output logic [LEN_W-1:0]  busLen,
  output logic [DATA_W-1:0] busData
);
  logic [ADDR_W-1:0] entStart [ENTRIES];
  logic [LEN_W-1:0]  entLen   [ENTRIES];
  logic [DATA_W-1:0] entWord  [ENTRIES][WORDS];
  logic [ENTRIES-1:0] entValid;
  logic [ADDR_W-1:0] byAddr;
  logic [DATA_W-1:0] byData;

  logic [ADDR_W-1:0] offs [ENTRIES];
  logic [ENTRIES-1:0] hitVec;

  for (genvar e = 0; e < ENTRIES; e++) begin : gHit
    assign offs[e]   = stAddr - entStart[e];
    assign hitVec[e] = entValid[e] && (offs[e] < ADDR_W'(entLen[e]));
  end

  always_comb begin
    hit     = 1'b0;
    hitEnt  = '0;
    hitWord = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (hitVec[e] && !hit) begin
        hit     = 1'b1;
        hitEnt  = ENT_W'(e);
        hitWord = offs[e][WORD_W-1:0];
      end
    end
  end

  assign youngLen = entLen[youngIdx];
  assign headLen  = entLen[headIdx];
  assign appendOk = entValid[youngIdx] && (youngLen < LEN_W'(WORDS)) &&
                    (stAddr == entStart[youngIdx] + ADDR_W'(youngLen));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
    end else begin
      if (stb.alloc) entValid[stb.ent] <= 1'b1;
      if (stb.pop)   entValid[stb.ent] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        entLen[e]   <= '0;
        entStart[e] <= '0;
      end
    end else if (stb.alloc) begin
      entStart[stb.ent] <= stAddr;
      entLen[stb.ent]   <= LEN_W'(1);
    end else if (stb.append) begin
      entLen[stb.ent] <= entLen[stb.ent] + LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.alloc)          entWord[stb.ent][0] <= stData;
    else if (stb.append)    entWord[stb.ent][entLen[stb.ent][WORD_W-1:0]] <= stData;
    else if (stb.overwrite) entWord[stb.ent][stb.word] <= stData;
    if (stb.byLoad) begin
      byAddr <= stAddr;
      byData <= stData;
    end
  end

  assign busAddr = stb.selBy ? byAddr : entStart[headIdx];
  assign busData = stb.selBy ? byData : entWord[headIdx][beatIdx];
  assign busLen  = stb.selBy ? LEN_W'(1) : headLen;
endmodule

// File: rtl/wcbCtrl.sv
module wcbCtrl
  import wcbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgEn,
  input  logic              stValid,
  input  logic              stBypass,
  input  logic              evtExc,
  input  logic              evtBarrier,
  input  logic              evtSleep,
  input  logic              busReady,
  input  logic              hit,
  input  logic [ENT_W-1:0]  hitEnt,
  input  logic [WORD_W-1:0] hitWord,
  input  logic              appendOk,
  input  logic [LEN_W-1:0]  youngLen,
  input  logic [LEN_W-1:0]  headLen,
  output wcbStb_t           stb,
  output logic              stReady,
  output logic              busValid,
  output logic              busLast,
  output logic [ENT_W-1:0]  headIdx,
  output logic [ENT_W-1:0]  youngIdx,
  output logic [WORD_W-1:0] beatIdx,
  output logic              drainDone,
  output logic              bufEmpty
);
  wcbState_e         state, nState;
  logic [ENT_W-1:0]  head, nHead, tailIdx;
  logic [CNT_W-1:0]  count, nCount;
  logic [WORD_W-1:0] beat, nBeat;
  logic              enReg, doneSet, canTake, fillTrig, bypassReq, evtAny, pending;

  assign bypassReq = stBypass || !enReg;
  assign evtAny    = evtExc || evtBarrier || evtSleep;
  assign pending   = (count != '0);
  assign tailIdx   = head + ENT_W'(count);
  assign youngIdx  = tailIdx - ENT_W'(1);
  assign headIdx   = head;
  assign beatIdx   = beat;
  assign bufEmpty  = !pending;

  always_comb begin
    stb      = '0;
    nState   = state;
    nHead    = head;
    nCount   = count;
    nBeat    = beat;
    doneSet  = 1'b0;
    canTake  = 1'b0;
    fillTrig = 1'b0;
    busValid = 1'b0;
    busLast  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        canTake = !(bypassReq && pending);
        if (stValid && canTake) begin
          if (bypassReq) begin
            stb.byLoad = 1'b1;
            nState     = ST_BYPASS;
          end else if (hit) begin
            stb.overwrite = 1'b1;
            stb.ent       = hitEnt;
            stb.word      = hitWord;
          end else if (appendOk) begin
            stb.append = 1'b1;
            stb.ent    = youngIdx;
            fillTrig   = (youngLen == LEN_W'(WORDS - 1));
          end else begin
            stb.alloc = 1'b1;
            stb.ent   = tailIdx;
            nCount    = count + CNT_W'(1);
            fillTrig  = (nCount == CNT_W'(ENTRIES));
          end
        end
        if (nState == ST_IDLE &&
            (fillTrig || (evtAny && nCount != '0) || (stValid && bypassReq && pending)))
          nState = ST_DRAIN;
      end
      ST_DRAIN: begin
        busValid = 1'b1;
        busLast  = (LEN_W'(beat) == headLen - LEN_W'(1));
        if (busReady) begin
          if (busLast) begin
            stb.pop = 1'b1;
            stb.ent = head;
            nHead   = head + ENT_W'(1);
            nCount  = count - CNT_W'(1);
            nBeat   = '0;
            if (count == CNT_W'(1)) begin
              nState  = ST_IDLE;
              doneSet = 1'b1;
            end
          end else begin
            nBeat = beat + WORD_W'(1);
          end
        end
      end
      ST_BYPASS: begin
        busValid  = 1'b1;
        busLast   = 1'b1;
        stb.selBy = 1'b1;
        if (busReady) nState = ST_IDLE;
      end
      default: nState = ST_IDLE;
    endcase
  end

  assign stReady = canTake;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      head      <= '0;
      count     <= '0;
      beat      <= '0;
      enReg     <= 1'b1;
      drainDone <= 1'b0;
    end else begin
      state     <= nState;
      head      <= nHead;
      count     <= nCount;
      beat      <= nBeat;
      drainDone <= doneSet;
      if (cfgWe) enReg <= cfgEn;
    end
  end
endmodule

// File: rtl/wrCoalesceBuffer.sv
module wrCoalesceBuffer
  import wcbPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgEn,
  input  logic              stValid,
  output logic              stReady,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic              stBypass,
  input  logic              evtExc,
  input  logic              evtBarrier,
  input  logic              evtSleep,
  output logic              busValid,
  input  logic              busReady,
  output logic [ADDR_W-1:0] busAddr,
  output logic [2:0]        busLen,
  output logic [DATA_W-1:0] busData,
  output logic              busLast,
  output logic              drainDone,
  output logic              bufEmpty
);
  wcbStb_t           stb;
  logic              hit, appendOk;
  logic [ENT_W-1:0]  hitEnt, headIdx, youngIdx;
  logic [WORD_W-1:0] hitWord, beatIdx;
  logic [LEN_W-1:0]  youngLen, headLen, lenOut;

  wcbCtrl uCtrl (
    .clk, .rstN, .cfgWe, .cfgEn, .stValid, .stBypass,
    .evtExc, .evtBarrier, .evtSleep, .busReady,
    .hit, .hitEnt, .hitWord, .appendOk, .youngLen, .headLen,
    .stb, .stReady, .busValid, .busLast,
    .headIdx, .youngIdx, .beatIdx, .drainDone, .bufEmpty
  );

  wcbData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uData (
    .clk, .rstN, .stb, .stAddr, .stData,
    .headIdx, .youngIdx, .beatIdx,
    .hit, .hitEnt, .hitWord, .appendOk, .youngLen, .headLen,
    .busAddr, .busLen(lenOut), .busData
  );

  assign busLen = 3'(lenOut);
endmodule

// File: rtl/wcbChecker.sv
module wcbChecker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 30
) (
  input logic              clk,
  input logic              rstN,
  input logic              stValid,
  input logic              stReady,
  input logic              stBypass,
  input logic              busValid,
  input logic              busReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic [2:0]        busLen,
  input logic [DATA_W-1:0] busData,
  input logic              drainDone,
  input logic              bufEmpty
);
  AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> !stReady); // R5

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> (busValid && $stable(busAddr) && $stable(busData) && $stable(busLen))); // R10

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busLen >= 3'd1 && busLen <= 3'd4)); // R2

  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    drainDone |-> bufEmpty); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    drainDone |=> !drainDone); // R11

  AST_BYPASS_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && stBypass && !bufEmpty) |-> !stReady); // R8

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rstN)
    (bufEmpty && !busValid) |-> stReady); // R1
endmodule

bind wrCoalesceBuffer wcbChecker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady), .stBypass(stBypass),
  .busValid(busValid), .busReady(busReady), .busAddr(busAddr), .busLen(busLen),
  .busData(busData), .drainDone(drainDone), .bufEmpty(bufEmpty)
);

// File: tb/wrCoalesceBuffer_test.sv
module wrCoalesceBuffer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0, cfgEn = 1'b1;
  logic        stValid = 1'b0, stBypass = 1'b0;
  logic [29:0] stAddr = '0;
  logic [31:0] stData = '0;
  logic        evtExc = 1'b0, evtBarrier = 1'b0, evtSleep = 1'b0;
  logic        busReady = 1'b1;
  logic        stReady, busValid, busLast, drainDone, bufEmpty;
  logic [29:0] busAddr;
  logic [2:0]  busLen;
  logic [31:0] busData;

  int    nChecks = 0, nFails = 0, cyc = 0;
  string curReq = "R1";

  typedef struct {
    logic [29:0] addr;
    logic [2:0]  len;
    logic [31:0] data;
    logic        last;
  } beat_t;
  beat_t expQ[$];

  wrCoalesceBuffer uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic expectBeat(input logic [29:0] a, input logic [2:0] l, input logic [31:0] d, input bit last);
    beat_t b;
    b.addr = a; b.len = l; b.data = d; b.last = last;
    expQ.push_back(b);
  endtask

  // backpressure: bus stalls one cycle in three
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    busReady = (cyc % 3) != 1;
  end

  // monitor: pop and compare each accepted beat; check held beats (R10)
  logic        heldV = 1'b0;
  logic [29:0] heldA;
  logic [31:0] heldD;
  always @(negedge clk) begin
    if (rstN) begin
      if (heldV)
        chk(busValid && busAddr == heldA && busData == heldD, "R10 held beat",
            {busAddr, busData}, {heldA, heldD});
      heldV = busValid && !busReady;
      heldA = busAddr;
      heldD = busData;
      if (busValid && busReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, {curReq, " unexpected beat"}, busAddr, 0);
        end else begin
          beat_t e;
          e = expQ.pop_front();
          chk(busAddr == e.addr && busLen == e.len, {curReq, " beat addr/len"},
              {busAddr, busLen}, {e.addr, e.len});
          chk(busData == e.data, {curReq, " beat data"}, busData, e.data);
          chk(busLast == e.last, "R10 last flag", busLast, e.last);
        end
      end
    end
  end

  task automatic doStore(input logic [29:0] a, input logic [31:0] d, input bit byp, input bit evt);
    bit rdy;
    @(posedge clk); #1;
    stValid = 1'b1; stAddr = a; stData = d; stBypass = byp; evtBarrier = evt;
    rdy = 1'b0;
    while (!rdy) begin
      @(negedge clk);
      rdy = stReady;
      @(posedge clk); #1;
      evtBarrier = 1'b0;
    end
    stValid = 1'b0; stBypass = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(posedge clk); #1;
    if (which == 0) evtExc = 1'b1;
    else if (which == 1) evtBarrier = 1'b1;
    else evtSleep = 1'b1;
    @(posedge clk); #1;
    evtExc = 1'b0; evtBarrier = 1'b0; evtSleep = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    while (!drainDone) @(negedge clk);
    chk(bufEmpty, tag, bufEmpty, 1);
    @(negedge clk);
    chk(!drainDone, tag, drainDone, 0);
  endtask

  task automatic waitQuiet();
    while (expQ.size() != 0 || busValid) @(negedge clk);
  endtask

  task automatic setEn(input bit v);
    @(posedge clk); #1;
    cfgWe = 1'b1; cfgEn = v;
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    nFails++;
    $display("FAIL R1 watchdog: actual hung, expected finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(bufEmpty, "R1 empty", bufEmpty, 1);
    chk(!busValid, "R1 busValid", busValid, 0);
    chk(stReady, "R1 stReady", stReady, 1);

    // R2 merge, R3 overwrite, R9 enabled out of reset, drained by barrier
    curReq = "R2";
    doStore(30'h100, 32'hA0, 0, 0);
    doStore(30'h101, 32'hA1, 0, 0);
    doStore(30'h100, 32'hB0, 0, 0);
    doStore(30'h102, 32'hA2, 0, 0);
    repeat (3) @(negedge clk);
    chk(!busValid && !bufEmpty, "R9 held while enabled", {busValid, bufEmpty}, 2'b00);
    expectBeat(30'h100, 3, 32'hB0, 0);
    expectBeat(30'h100, 3, 32'hA1, 0);
    expectBeat(30'h100, 3, 32'hA2, 1);
    pulse(1);
    waitDone("R11 done pulse");
    waitQuiet();

    // R4 separate entries drain in order on exception; R6 idle strobe
    curReq = "R4";
    doStore(30'h200, 32'hC0, 0, 0);
    doStore(30'h300, 32'hC1, 0, 0);
    doStore(30'h205, 32'hC2, 0, 0);
    expectBeat(30'h200, 1, 32'hC0, 1);
    expectBeat(30'h300, 1, 32'hC1, 1);
    expectBeat(30'h205, 1, 32'hC2, 1);
    pulse(0);
    waitDone("R6 exception drain");
    waitQuiet();
    @(posedge clk); #1 evtSleep = 1'b1;
    @(negedge clk);
    chk(stReady, "R6 idle strobe stReady", stReady, 1);
    @(posedge clk); #1 evtSleep = 1'b0;
    @(negedge clk);
    chk(!busValid && bufEmpty, "R6 idle strobe no effect", {busValid, bufEmpty}, 2'b01);

    // R5 fill by words
    curReq = "R5";
    expectBeat(30'h400, 4, 32'hD0, 0);
    expectBeat(30'h400, 4, 32'hD1, 0);
    expectBeat(30'h400, 4, 32'hD2, 0);
    expectBeat(30'h400, 4, 32'hD3, 1);
    for (int i = 0; i < 4; i++) doStore(30'h400 + 30'(i), 32'hD0 + 32'(i), 0, 0);
    @(negedge clk);
    chk(!stReady && busValid, "R5 word fill stalls", {stReady, busValid}, 2'b01);
    waitDone("R5 word fill done");
    waitQuiet();

    // R5 fill by entries
    for (int i = 0; i < 4; i++) expectBeat(30'h500 + 30'(i * 16), 1, 32'hE0 + 32'(i), 1);
    for (int i = 0; i < 4; i++) doStore(30'h500 + 30'(i * 16), 32'hE0 + 32'(i), 0, 0);
    @(negedge clk);
    chk(!stReady, "R5 entry fill stalls", stReady, 0);
    waitDone("R5 entry fill done");
    waitQuiet();

    // R7 bypass into empty buffer
    curReq = "R7";
    expectBeat(30'h600, 1, 32'hF0, 1);
    doStore(30'h600, 32'hF0, 1, 0);
    @(negedge clk);
    chk(busValid && busLen == 1 && !stReady, "R7 single beat", {busValid, busLen, stReady}, {1'b1, 3'd1, 1'b0});
    waitQuiet();

    // R8 bypass behind pending entry
    curReq = "R8";
    expectBeat(30'h700, 1, 32'h70, 1);
    expectBeat(30'h800, 1, 32'h80, 1);
    doStore(30'h700, 32'h70, 0, 0);
    doStore(30'h800, 32'h80, 1, 0);
    waitQuiet();
    chk(expQ.size() == 0, "R8 order", expQ.size(), 0);

    // R12 store and barrier in the same cycle
    curReq = "R12";
    expectBeat(30'h900, 2, 32'h90, 0);
    expectBeat(30'h900, 2, 32'h91, 1);
    doStore(30'h900, 32'h90, 0, 0);
    doStore(30'h901, 32'h91, 0, 1);
    waitDone("R12 merged drain");
    waitQuiet();

    // R9 disable buffering
    curReq = "R9";
    setEn(0);
    expectBeat(30'hA00, 1, 32'hAA, 1);
    doStore(30'hA00, 32'hAA, 0, 0);
    @(negedge clk);
    chk(busValid && busLen == 1, "R9 disabled single beat", {busValid, busLen}, {1'b1, 3'd1});
    expectBeat(30'hA01, 1, 32'hAB, 1);
    doStore(30'hA01, 32'hAB, 0, 0);
    waitQuiet();
    setEn(1);
    doStore(30'hB00, 32'hBB, 0, 0);
    repeat (3) @(negedge clk);
    chk(!busValid && !bufEmpty, "R9 re-enabled holds", {busValid, bufEmpty}, 2'b00);
    expectBeat(30'hB00, 1, 32'hBB, 1);
    pulse(2);
    waitDone("R6 sleep drain");
    waitQuiet();

    chk(expQ.size() == 0, "R4 all beats seen", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule